// File: doc/BRIEF.md
# Interrupt Event Latch and Mask Bank

This block holds the interrupt state of a serial bus controller. Nine single-cycle event pulses from the controller are captured into a sticky status word. A mask word selects which captured events may raise the shared interrupt line. Software reads the status word and clears serviced bits by writing ones to them. The mask is never written directly: one write-only port clears mask bits to let sources through, and a second write-only port sets mask bits to block them. The mask itself can be read back at its own offset.

All four views use the same 10-bit layout. Bit 8 is unused, so the ninth event input feeds bit 9. The register port is a plain single-cycle bus: a write strobe, a byte address and a 32-bit write word. The read word is a combinational function of the address.

Top module: `irq_event_bank`

## Requirements
- R1: After reset the status word reads 0x000, the mask word reads 0x2FF (every live source blocked) and `irq_out` is low.
- R2: A high level on `ev_in[k]` for k in 0..7 sets status bit k at the next clock edge, and `ev_in[8]` sets status bit 9. The bit stays set after the pulse ends.
- R3: A write to offset 0x10 clears every status bit whose write-data bit is 1 and leaves the other status bits unchanged.
- R4: When an event pulse and a write of 1 to the same status bit fall in the same cycle, the bit is set after that edge.
- R5: A write to offset 0x24 clears the mask bit of every live source whose write-data bit is 1. Zeros leave their mask bits unchanged.
- R6: A write to offset 0x28 sets the mask bit of every live source whose write-data bit is 1. Zeros leave their mask bits unchanged.
- R7: Offset 0x10 reads the status word and offset 0x20 reads the mask word, where 1 means blocked. Offsets 0x24 and 0x28 read as zero.
- R8: `irq_out` is high exactly when some status bit is set whose mask bit is 0. It follows the same clock edge that updates either word.
- R9: Bit 8 and bits 10..31 of both words always read 0, and write-data in those positions has no effect on any word.
- R10: A blocked source still latches into the status word. Unmasking it later raises `irq_out` with no new event.
- R11: Writes to unmapped offsets change neither word, and reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Write strobe, one write per cycle it is high |
| reg_addr | input | 8 | Byte offset of the accessed register |
| reg_wdata | input | 32 | Write word |
| reg_rdata | output | 32 | Read word for `reg_addr`, combinational |
| ev_in | input | 9 | Event pulses, one per source |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Every stored bit appears on the read port one cycle after the edge that changed it. A corrupted status or mask flop therefore shows up at the next read of offset 0x10 or 0x20, and `irq_out` shows the same fault in the same cycle whenever the bit is unmasked. The risky cases are two actions on one bit in one cycle, the reserved bit 8 between live neighbours, and the remapping of the ninth event input. The directed scenarios place reads right after each such edge, so a wrong priority or a wrong bit position is seen within one cycle.

// File: rtl/irq_bank_pkg.sv
// Shared constants for the interrupt event bank.
// Assumes one 10-bit layout for status and mask, with bit 8 unused.
package irq_bank_pkg;

    localparam int SRC_W = 10;
    localparam int EV_N  = 9;

    // Positions that hold a real flop in both words.
    localparam logic [SRC_W-1:0] LIVE_BITS = 10'b10_1111_1111;

    // Byte offsets of the register views.
    localparam int OFS_STATUS  = 'h10;
    localparam int OFS_MASK    = 'h20;
    localparam int OFS_ENABLE  = 'h24;
    localparam int OFS_DISABLE = 'h28;

    // Address match flags produced by the decoder.
    typedef struct packed {
        logic stat;
        logic mask;
        logic unmask;
        logic block;
    } reg_hit_t;

    // Spread the nine event inputs over the 10-bit layout (bit 8 skipped).
    function automatic logic [SRC_W-1:0] ev_to_map(input logic [EV_N-1:0] ev);
        return {ev[8], 1'b0, ev[7:0]};
    endfunction

endpackage

// File: rtl/irq_addr_dec.sv
// Address decoder: flags which register view an offset selects.
// Assumes exact byte offsets. Any other offset selects nothing.
module irq_addr_dec
    import irq_bank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_hit_t          hit
);

    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_UNMSK = ADDR_W'(OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_BLOCK = ADDR_W'(OFS_DISABLE);

    // Compare the offset against each view.
    always_comb begin
        hit.stat   = (addr == A_STAT);
        hit.mask   = (addr == A_MASK);
        hit.unmask = (addr == A_UNMSK);
        hit.block  = (addr == A_BLOCK);
    end

endmodule

// File: rtl/irq_status_bank.sv
// Sticky status word: a set pulse latches a bit, a clear request drops it.
// Assumes set has priority over clear. Non-live positions hold constant 0.
module irq_status_bank
    import irq_bank_pkg::*;
#(
    parameter int                W    = SRC_W,
    parameter logic [SRC_W-1:0]  LIVE = LIVE_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] stat_q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (LIVE[i]) begin : g_live
            // Latch the event; an event in the clear cycle wins.
            always_ff @(posedge clk) begin
                if (!rst_n)          stat_q[i] <= 1'b0;
                else if (set_vec[i]) stat_q[i] <= 1'b1;
                else if (clr_vec[i]) stat_q[i] <= 1'b0;
            end
        end else begin : g_rsvd
            assign stat_q[i] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_mask_bank.sv
// Mask word, 1 = blocked. Changed only through separate block and unblock requests.
// Assumes at most one request per bit per cycle; block wins if both occur.
module irq_mask_bank
    import irq_bank_pkg::*;
#(
    parameter int                W    = SRC_W,
    parameter logic [SRC_W-1:0]  LIVE = LIVE_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] block_vec,
    input  logic [W-1:0] unblock_vec,
    output logic [W-1:0] mask_q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (LIVE[i]) begin : g_live
            // Reset to blocked, then follow block/unblock requests.
            always_ff @(posedge clk) begin
                if (!rst_n)              mask_q[i] <= 1'b1;
                else if (block_vec[i])   mask_q[i] <= 1'b1;
                else if (unblock_vec[i]) mask_q[i] <= 1'b0;
            end
        end else begin : g_rsvd
            assign mask_q[i] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_event_bank.sv
// Interrupt register set of a serial controller: sticky status, write-one-clear,
// write-only unblock and block ports, a readable mask and one request line.
// Assumes single-cycle register writes and a combinational read port.
module irq_event_bank
    import irq_bank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [EV_N-1:0]   ev_in,
    output logic              irq_out
);

    localparam int PAD_W = DATA_W - SRC_W;

    reg_hit_t          hit;
    logic [SRC_W-1:0]  wbits;
    logic [SRC_W-1:0]  ev_map;
    logic [SRC_W-1:0]  stat_clr;
    logic [SRC_W-1:0]  mask_set;
    logic [SRC_W-1:0]  mask_clr;
    logic [SRC_W-1:0]  stat_q;
    logic [SRC_W-1:0]  mask_q;

    irq_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (reg_addr),
        .hit  (hit)
    );

    // Form the per-bit requests from the write and the events.
    always_comb begin
        wbits    = reg_wdata[SRC_W-1:0] & LIVE_BITS;
        ev_map   = ev_to_map(ev_in);
        stat_clr = (reg_wr && hit.stat)   ? wbits : '0;
        mask_set = (reg_wr && hit.block)  ? wbits : '0;
        mask_clr = (reg_wr && hit.unmask) ? wbits : '0;
    end

    irq_status_bank u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (ev_map),
        .clr_vec (stat_clr),
        .stat_q  (stat_q)
    );

    irq_mask_bank u_mask (
        .clk         (clk),
        .rst_n       (rst_n),
        .block_vec   (mask_set),
        .unblock_vec (mask_clr),
        .mask_q      (mask_q)
    );

    // Return the addressed view. Write-only and unmapped offsets read zero.
    always_comb begin
        reg_rdata = '0;
        if (hit.stat)      reg_rdata = {{PAD_W{1'b0}}, stat_q};
        else if (hit.mask) reg_rdata = {{PAD_W{1'b0}}, mask_q};
    end

    // Raise the request for any pending source that is not blocked.
    assign irq_out = |(stat_q & ~mask_q);

endmodule

// File: rtl/irq_event_bank_chk.sv
// Temporal checks for irq_event_bank, attached with bind.
// Assumes it sees the top-level ports and the two stored words.
module irq_event_bank_chk
    import irq_bank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [EV_N-1:0]   ev_in,
    input logic              irq_out,
    input logic [SRC_W-1:0]  stat_q,
    input logic [SRC_W-1:0]  mask_q
);

    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_UNMSK = ADDR_W'(OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_BLOCK = ADDR_W'(OFS_DISABLE);

    logic [SRC_W-1:0] ev_bits;
    logic [SRC_W-1:0] w_live;
    assign ev_bits = ev_to_map(ev_in);
    assign w_live  = reg_wdata[SRC_W-1:0] & LIVE_BITS;

    // R2
    ev_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_bits != '0) |=> ((stat_q & $past(ev_bits)) == $past(ev_bits)));

    // R3
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_STAT) |=>
        ((stat_q & $past(w_live & ~ev_bits)) == '0));

    // R5
    unmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_UNMSK) |=> ((mask_q & $past(w_live)) == '0));

    // R6
    block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_BLOCK) |=>
        ((mask_q & $past(w_live)) == $past(w_live)));

    // R8
    irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q == '0) |-> !irq_out);

    // R8
    irq_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == LIVE_BITS) |-> !irq_out);

endmodule

bind irq_event_bank irq_event_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ev_in     (ev_in),
    .irq_out   (irq_out),
    .stat_q    (stat_q),
    .mask_q    (mask_q)
);

// File: tb/irq_event_bank_bench.sv
// Directed bench for irq_event_bank: one task per scenario, each checking its own results.
module irq_event_bank_bench;

    localparam logic [7:0] A_STAT  = 8'h10;
    localparam logic [7:0] A_MASK  = 8'h20;
    localparam logic [7:0] A_UNMSK = 8'h24;
    localparam logic [7:0] A_BLOCK = 8'h28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [8:0]  ev_in = 9'h0;
    logic        irq_out;

    int vecs = 0;
    int miss = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_event_bank u_irq_event_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ev_in     (ev_in),
        .irq_out   (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 32'h0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic [8:0] ev);
        @(negedge clk);
        ev_in = ev;
        @(negedge clk);
        ev_in = 9'h0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_STAT, d); chk("R1 status after reset", d, 32'h000);
        rd(A_MASK, d); chk("R1 mask after reset", d, 32'h2FF);
        chk("R1 irq after reset", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_latch();
        logic [31:0] d;
        pulse(9'h001);
        rd(A_STAT, d); chk("R2 ev0 to bit0 sticky", d, 32'h001);
        pulse(9'h100);
        rd(A_STAT, d); chk("R2 ev8 to bit9", d, 32'h201);
        chk("R10 blocked sources keep irq low", {31'b0, irq_out}, 32'h0);
        wr(A_STAT, 32'h3FF);
        rd(A_STAT, d); chk("R3 clear all", d, 32'h000);
    endtask

    task automatic t_unblock();
        logic [31:0] d;
        wr(A_UNMSK, 32'h003);
        rd(A_MASK, d); chk("R5 unblock bits 0,1", d, 32'h2FC);
        wr(A_UNMSK, 32'h000);
        rd(A_MASK, d); chk("R5 zero write no change", d, 32'h2FC);
        pulse(9'h002);
        chk("R8 irq on unblocked bit1", {31'b0, irq_out}, 32'h1);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        pulse(9'h00F);
        rd(A_STAT, d); chk("R2 four events", d, 32'h00F);
        wr(A_STAT, 32'h005);
        rd(A_STAT, d); chk("R3 partial clear", d, 32'h00A);
        chk("R8 irq held by bit1", {31'b0, irq_out}, 32'h1);
        wr(A_STAT, 32'h002);
        rd(A_STAT, d); chk("R3 clear bit1", d, 32'h008);
        chk("R8 irq low, bit3 blocked", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_block();
        logic [31:0] d;
        wr(A_BLOCK, 32'h002);
        rd(A_MASK, d); chk("R6 block bit1", d, 32'h2FE);
        wr(A_BLOCK, 32'h000);
        rd(A_MASK, d); chk("R6 zero write no change", d, 32'h2FE);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h009; ev_in = 9'h001;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 32'h0; ev_in = 9'h0;
        rd(A_STAT, d); chk("R4 event beats clear", d, 32'h001);
        chk("R8 irq from unblocked bit0", {31'b0, irq_out}, 32'h1);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        wr(A_UNMSK, 32'hFFFF_FFFF);
        rd(A_MASK, d); chk("R9 unblock all", d, 32'h000);
        wr(A_BLOCK, 32'hFFFF_FFFF);
        rd(A_MASK, d); chk("R9 block all, bit8 stays 0", d, 32'h2FF);
        pulse(9'h1FF);
        rd(A_STAT, d); chk("R9 all events, bit8 0", d, 32'h2FF);
        wr(A_STAT, 32'hFFFF_FD00);
        rd(A_STAT, d); chk("R9 reserved clear bits ignored", d, 32'h2FF);
        wr(A_UNMSK, 32'hFFFF_FD00);
        rd(A_MASK, d); chk("R9 reserved unblock ignored", d, 32'h2FF);
        wr(A_STAT, 32'h3FF);
        rd(A_STAT, d); chk("R3 full clear", d, 32'h000);
    endtask

    task automatic t_views();
        logic [31:0] d;
        rd(A_UNMSK, d); chk("R7 unblock port reads 0", d, 32'h0);
        rd(A_BLOCK, d); chk("R7 block port reads 0", d, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        pulse(9'h004);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(A_STAT, d); chk("R11 status untouched", d, 32'h004);
        rd(A_MASK, d); chk("R11 mask untouched", d, 32'h2FF);
        rd(8'h14, d);  chk("R11 unmapped reads 0", d, 32'h0);
        wr(A_STAT, 32'h004);
    endtask

    task automatic t_pending();
        logic [31:0] d;
        pulse(9'h100);
        rd(A_STAT, d); chk("R10 blocked source latched", d, 32'h200);
        chk("R10 irq low while blocked", {31'b0, irq_out}, 32'h0);
        wr(A_UNMSK, 32'h200);
        chk("R10 irq on unblock", {31'b0, irq_out}, 32'h1);
        wr(A_BLOCK, 32'h200);
        chk("R8 irq low after block", {31'b0, irq_out}, 32'h0);
        rd(A_STAT, d); chk("R10 status kept", d, 32'h200);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latch();
        t_unblock();
        t_w1c();
        t_block();
        t_collide();
        t_reserved();
        t_views();
        t_unmapped();
        t_pending();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vecs++;
            miss++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
            $finish;
        end
    end

endmodule